// File: doc/BRIEF.md
# Wavefront Issue Sequencer

The sequencer runs several wavefronts on a SIMD array that is narrower than a wavefront. A wavefront has 64 threads that share one program counter. The array has 16 lanes, so each wide instruction is replayed over four consecutive cycles. Each cycle covers a different quarter of the threads. During those four cycles the same bundle of up to five operation slots goes unchanged to every lane. Each cycle also produces a register-file row address that picks out the thread rows of that quarter.

Every context slot holds one wavefront with its own program counter, so wavefronts can sit at different points of the same program. When a wavefront is launched, it starts at address 0. At each replay boundary the sequencer picks the next ready wavefront in round-robin order. It fetches that wavefront's instruction through a combinational fetch port and does one of three things:
- A bundle starts a four-cycle replay.
- A barrier parks the wavefront until every live wavefront has arrived.
- An end instruction retires the wavefront and frees its slot.

The lane arithmetic sits outside the block. It consumes `lane_en`, `rf_addr` and `iss_thread`.

Top module: `wave_issue_seq`

## Requirements
- R1: A new wavefront is picked only when no replay is running or the running replay is in its last quarter. The pick is round-robin among live, non-waiting slots, searching upward from the slot picked last and wrapping. The last-picked slot is considered last. After reset the search starts at slot 0.
- R2: A bundle issues on the four cycles that follow its fetch, with `iss_quarter` stepping 0, 1, 2, 3 and `iss_wf` held constant. Back-to-back bundles issue with no gap.
- R3: During issue, `rf_addr` is {wavefront id, quarter, register number}, with the register number in the low `REG_W` bits. `iss_thread` equals quarter × 16.
- R4: `lane_en` carries the fetched 5-bit slot mask on every issue cycle and is zero when nothing issues. A bundle with an all-zero mask still takes four cycles.
- R5: Instruction kind encoding: 2'b00 is a bundle, 2'b01 is a barrier, and 2'b10 or 2'b11 is end. A barrier or end consumes its pick cycle and issues nothing. A waiting wavefront is never picked.
- R6: A barrier completes in the same cycle that the last live wavefront either arrives at it or retires. All waiting wavefronts are released together, each with its program counter advanced past its barrier.
- R7: An end instruction frees the slot, and `done_valid` pulses for one cycle on the next cycle with `done_wf` naming the slot.
- R8: A set `start` bit for a free slot makes it live at program counter 0 on the next cycle. A set `start` bit for a live slot is ignored and leaves its program counter unchanged.
- R9: After reset no slot is live, nothing issues, nothing is fetched and `done_valid` is low.
- R10: `fetch_req`, `fetch_wf` and `fetch_pc` present the picked slot and its program counter in the pick cycle. The instruction inputs are consumed in that same cycle, and the program counter advances by one for a bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | NUM_WF | Launch request per context slot |
| fetch_req | output | 1 | A pick happens this cycle |
| fetch_wf | output | WF_W | Picked slot |
| fetch_pc | output | PC_W | Program counter of the picked slot |
| ins_kind | input | 2 | Instruction kind for the fetch address |
| ins_slots | input | SLOTS | Slot-valid mask of the bundle |
| ins_reg | input | REG_W | Register number of the bundle |
| iss_valid | output | 1 | A bundle quarter is issuing |
| iss_wf | output | WF_W | Issuing wavefront |
| iss_quarter | output | QW | Quarter being issued |
| iss_thread | output | TW | First thread index of the quarter |
| lane_en | output | SLOTS | Active operation slots broadcast to all lanes |
| rf_addr | output | AW | Register-file row address |
| done_valid | output | 1 | One-cycle retirement pulse |
| done_wf | output | WF_W | Retired slot |

## Verification
The bench uses wavefronts whose barriers sit at different program counters. This catches three kinds of fault:
- A release that fires one cycle late or forgets to advance the program counters. The wavefronts would re-execute the barrier and hang.
- A barrier that completes on a partial arrival count.

A second phase lets one wavefront wait at a barrier while the only other live wavefront retires. A design that counts only arrivals would never free the waiter.

Two further cases are covered:
- An all-zero slot mask. A design that skipped such a bundle would shift every later issue.
- A repeated `start` on a running slot. A design that re-launched the slot would restart its program.

The bench also compares the round-robin order and the pick timing at every quarter-3 boundary. This would expose a scheduler that stalls a cycle between bundles or that starts its search at the wrong slot.

// File: rtl/wave_issue_seq.sv
module wave_issue_seq #(
  parameter int NUM_WF       = 4,
  parameter int WAVE_THREADS = 64,
  parameter int LANES        = 16,
  parameter int SLOTS        = 5,
  parameter int PC_W         = 8,
  parameter int REG_W        = 6,
  localparam int WF_W     = (NUM_WF > 1) ? $clog2(NUM_WF) : 1,
  localparam int QUARTERS = WAVE_THREADS / LANES,
  localparam int QW       = $clog2(QUARTERS),
  localparam int TW       = $clog2(WAVE_THREADS),
  localparam int AW       = WF_W + QW + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_WF-1:0] start,
  output logic              fetch_req,
  output logic [WF_W-1:0]   fetch_wf,
  output logic [PC_W-1:0]   fetch_pc,
  input  logic [1:0]        ins_kind,
  input  logic [SLOTS-1:0]  ins_slots,
  input  logic [REG_W-1:0]  ins_reg,
  output logic              iss_valid,
  output logic [WF_W-1:0]   iss_wf,
  output logic [QW-1:0]     iss_quarter,
  output logic [TW-1:0]     iss_thread,
  output logic [SLOTS-1:0]  lane_en,
  output logic [AW-1:0]     rf_addr,
  output logic              done_valid,
  output logic [WF_W-1:0]   done_wf
);

  logic [NUM_WF-1:0] active, waiting, ready, sel_oh, launch, act_n, wait_n;
  logic [PC_W-1:0]   pc [NUM_WF];
  logic [WF_W-1:0]   rr, sel, cur_wf;
  logic [QW-1:0]     q;
  logic [REG_W-1:0]  cur_reg;
  logic [SLOTS-1:0]  cur_slots;
  logic              busy, found, boundary, take, is_bundle, arrive, retire, release_all;

  assign ready = active & ~waiting;

  always_comb begin
    logic [WF_W-1:0] idx;
    found = 1'b0;
    sel   = '0;
    for (int k = 1; k <= NUM_WF; k++) begin
      idx = rr + WF_W'(k);
      if (!found && ready[idx]) begin
        found = 1'b1;
        sel   = idx;
      end
    end
  end

  assign boundary  = !busy || (q == QW'(QUARTERS - 1));
  assign take      = boundary && found;
  assign sel_oh    = NUM_WF'(1) << sel;
  assign is_bundle = (ins_kind == 2'b00);
  assign arrive    = take && (ins_kind == 2'b01);
  assign retire    = take && ins_kind[1];
  assign launch    = start & ~active;

  assign act_n       = (active & ~(retire ? sel_oh : '0)) | launch;
  assign wait_n      = (waiting | (arrive ? sel_oh : '0)) & ~launch;
  assign release_all = (|act_n) && ((act_n & ~wait_n) == '0);

  assign fetch_req = take;
  assign fetch_wf  = sel;
  assign fetch_pc  = pc[sel];

  assign iss_valid   = busy;
  assign iss_wf      = cur_wf;
  assign iss_quarter = q;
  assign iss_thread  = TW'(int'(q) * LANES);
  assign lane_en     = busy ? cur_slots : '0;
  assign rf_addr     = {cur_wf, q, cur_reg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= '0;
      waiting    <= '0;
      rr         <= WF_W'(NUM_WF - 1);
      busy       <= 1'b0;
      q          <= '0;
      cur_wf     <= '0;
      cur_reg    <= '0;
      cur_slots  <= '0;
      done_valid <= 1'b0;
      done_wf    <= '0;
      for (int i = 0; i < NUM_WF; i++) pc[i] <= '0;
    end else begin
      done_valid <= retire;
      if (retire) done_wf <= sel;
      if (take) rr <= sel;
      if (take && is_bundle) begin
        busy      <= 1'b1;
        q         <= '0;
        cur_wf    <= sel;
        cur_reg   <= ins_reg;
        cur_slots <= ins_slots;
      end else if (boundary) begin
        busy <= 1'b0;
      end else begin
        q <= q + 1'b1;
      end
      active  <= act_n;
      waiting <= release_all ? '0 : wait_n;
      for (int i = 0; i < NUM_WF; i++) begin
        if (launch[i])
          pc[i] <= '0;
        else if ((take && is_bundle && sel == WF_W'(i)) || (release_all && wait_n[i]))
          pc[i] <= pc[i] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wave_issue_seq_chk.sv
module wave_issue_seq_chk #(
  parameter int WF_W = 2,
  parameter int QW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_req,
  input logic [WF_W-1:0] fetch_wf,
  input logic [1:0]      ins_kind,
  input logic            iss_valid,
  input logic [WF_W-1:0] iss_wf,
  input logic [QW-1:0]   iss_quarter,
  input logic            done_valid,
  input logic [WF_W-1:0] done_wf
);

  AST_REPLAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_quarter != '1 |=> iss_valid && iss_quarter == QW'($past(iss_quarter) + 1'b1) && iss_wf == $past(iss_wf)); // R2

  AST_REPLAY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iss_valid) |-> iss_quarter == '0); // R2

  AST_PICK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> !iss_valid || iss_quarter == '1); // R1

  AST_FETCH_TO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && ins_kind == 2'b00 |=> iss_valid && iss_quarter == '0 && iss_wf == $past(fetch_wf)); // R10

  AST_CTRL_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && ins_kind != 2'b00 |=> !iss_valid); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !(done_valid && done_wf == $past(done_wf))); // R7

endmodule

bind wave_issue_seq wave_issue_seq_chk #(.WF_W(WF_W), .QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_wf(fetch_wf),
  .ins_kind(ins_kind), .iss_valid(iss_valid), .iss_wf(iss_wf),
  .iss_quarter(iss_quarter), .done_valid(done_valid), .done_wf(done_wf)
);

// File: tb/test_wave_issue_seq.sv
module test_wave_issue_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] start = '0;
  logic       fetch_req;
  logic [1:0] fetch_wf;
  logic [7:0] fetch_pc;
  logic [1:0] ins_kind;
  logic [4:0] ins_slots;
  logic [5:0] ins_reg;
  logic       iss_valid;
  logic [1:0] iss_wf;
  logic [1:0] iss_quarter;
  logic [5:0] iss_thread;
  logic [4:0] lane_en;
  logic [9:0] rf_addr;
  logic       done_valid;
  logic [1:0] done_wf;

  int total = 0, bad = 0, prog_sel = 0, dones = 0, cycles = 0;
  bit running = 0;

  always #4 clk = ~clk;

  wave_issue_seq i_wave_issue_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .fetch_req(fetch_req), .fetch_wf(fetch_wf), .fetch_pc(fetch_pc),
    .ins_kind(ins_kind), .ins_slots(ins_slots), .ins_reg(ins_reg),
    .iss_valid(iss_valid), .iss_wf(iss_wf), .iss_quarter(iss_quarter),
    .iss_thread(iss_thread), .lane_en(lane_en), .rf_addr(rf_addr),
    .done_valid(done_valid), .done_wf(done_wf));

  // returns {kind[1:0], slots[4:0], reg[5:0]}
  function automatic logic [12:0] prog(input int wf, input int pc, input int ps);
    int kind, slots, rg;
    slots = (5'h1f ^ (wf + pc)) & 31;
    rg    = (pc * 3 + wf * 5) & 63;
    kind  = 2;
    if (ps == 0) begin
      if (pc <= wf) begin kind = 0; if (wf == 3 && pc == 0) slots = 0; end
      else if (pc == wf + 1) kind = 1;
      else if (pc == wf + 2) kind = 0;
    end else if (ps == 1) begin
      if (wf == 0) kind = (pc == 1) ? 1 : (pc < 3 ? 0 : 2);
      else if (wf == 1) kind = (pc < 3) ? 0 : 2;
    end else begin
      if (wf == 2 || wf == 3) kind = (pc < 6) ? 0 : 2;
    end
    return {kind[1:0], slots[4:0], rg[5:0]};
  endfunction

  assign {ins_kind, ins_slots, ins_reg} = prog(int'(fetch_wf), int'(fetch_pc), prog_sel);

  // reference model
  int  m_pc[4];
  bit  m_act[4], m_wait[4];
  int  m_rr, m_q, m_wf, m_reg, m_slots, m_done_wf;
  bit  m_busy, m_done;

  function automatic bit m_boundary();
    return !m_busy || m_q == 3;
  endfunction

  function automatic int m_pick();
    for (int k = 1; k <= 4; k++) begin
      int idx = (m_rr + k) % 4;
      if (m_act[idx] && !m_wait[idx]) return idx;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_pc[i] = 0; m_act[i] = 0; m_wait[i] = 0; end
      m_rr = 3; m_busy = 0; m_q = 0; m_done = 0;
    end else begin
      bit old_act[4];
      int s;
      bit any_live, all_wait;
      logic [12:0] w;
      for (int i = 0; i < 4; i++) old_act[i] = m_act[i];
      s = m_pick();
      m_done = 0;
      if (m_boundary() && s >= 0) begin
        w = prog(s, m_pc[s], prog_sel);
        m_rr = s;
        if (w[12:11] == 2'b00) begin
          m_busy = 1; m_q = 0; m_wf = s; m_reg = int'(w[5:0]); m_slots = int'(w[10:6]);
          m_pc[s] = (m_pc[s] + 1) & 255;
        end else begin
          m_busy = 0;
          if (w[12:11] == 2'b01) m_wait[s] = 1;
          else begin m_act[s] = 0; m_done = 1; m_done_wf = s; end
        end
      end else if (m_boundary()) m_busy = 0;
      else m_q = m_q + 1;
      for (int i = 0; i < 4; i++)
        if (start[i] && !old_act[i]) begin m_act[i] = 1; m_pc[i] = 0; m_wait[i] = 0; end
      any_live = 0; all_wait = 1;
      for (int i = 0; i < 4; i++) begin
        if (m_act[i]) any_live = 1;
        if (m_act[i] && !m_wait[i]) all_wait = 0;
      end
      if (any_live && all_wait)
        for (int i = 0; i < 4; i++)
          if (m_wait[i]) begin m_wait[i] = 0; m_pc[i] = (m_pc[i] + 1) & 255; end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && running) begin
      int s;
      s = m_boundary() ? m_pick() : -1;
      check(fetch_req == (s >= 0), "R1 fetch_req", fetch_req, s >= 0);
      if (s >= 0) begin
        check(int'(fetch_wf) == s, "R1 round-robin pick", fetch_wf, s);
        check(int'(fetch_pc) == m_pc[s], "R10 R6 R8 fetch_pc", fetch_pc, m_pc[s]);
      end
      check(iss_valid == m_busy, "R2 R5 iss_valid", iss_valid, m_busy);
      if (m_busy) begin
        check(int'(iss_wf) == m_wf, "R2 iss_wf", iss_wf, m_wf);
        check(int'(iss_quarter) == m_q, "R2 iss_quarter", iss_quarter, m_q);
        check(int'(rf_addr) == (m_wf * 256 + m_q * 64 + m_reg), "R3 rf_addr", rf_addr, m_wf * 256 + m_q * 64 + m_reg);
        check(int'(iss_thread) == m_q * 16, "R3 iss_thread", iss_thread, m_q * 16);
      end
      check(int'(lane_en) == (m_busy ? m_slots : 0), "R4 lane_en", lane_en, m_busy ? m_slots : 0);
      check(done_valid == m_done, "R7 done_valid", done_valid, m_done);
      if (m_done) check(int'(done_wf) == m_done_wf, "R7 done_wf", done_wf, m_done_wf);
      if (done_valid) dones++;
    end
  end

  task automatic pulse(input logic [3:0] v);
    @(negedge clk); start = v;
    @(negedge clk); start = '0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(iss_valid == 0 && fetch_req == 0 && done_valid == 0 && lane_en == 0, "R9 reset outputs", iss_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;
    check(fetch_req == 0, "R9 idle with no live slot", fetch_req, 0);
    prog_sel = 0;
    pulse(4'b1111);
    run(150);
    check(dones == 4, "R6 R7 barrier phase retirements", dones, 4);
    prog_sel = 1;
    pulse(4'b0011);
    run(80);
    check(dones == 6, "R6 release on retirement of last runner", dones, 6);
    prog_sel = 2;
    pulse(4'b0100);
    run(5);
    pulse(4'b0100);
    run(2);
    pulse(4'b1000);
    run(100);
    check(dones == 8, "R8 repeated start ignored", dones, 8);
    check(iss_valid == 0 && fetch_req == 0, "R7 all retired idle", iss_valid, 0);
    running = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    while (cycles < 5000) begin @(posedge clk); cycles++; end
    check(0, "watchdog expired", cycles, 5000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule